// File: doc/BRIEF.md
# Return Address Stack with Speculative Repair

This block keeps one circular stack of call-site addresses for each hardware thread. A fetch-side predictor uses it to predict where a return will go. A call pushes its own address. A return reads the top entry and pops it, and the predicted target is that entry plus the instruction size in bytes. When the stack is empty, the return is to be predicted not taken.

Both the top entry and its index are visible. A predictor can therefore save the (index, value) pair before it pops. If that pop later turns out to lie on a flushed path, one restore request writes the saved value back at the saved index and makes that index the top again. This rewinds the speculative pop in a single cycle.

The depth is a power of two and at most 16. When the stack overflows, it wraps and overwrites the oldest entry. The thread count is a parameter. In a given cycle the operation request and the read port both apply to the thread that `thr_i` selects.

Top module: `ras_mt`

## Requirements
- R1: After reset, every thread is empty (`empty_o`=1, `ret_valid_o`=0), its top index is 0 and its underflow flag is low.
- R2: A push with no restore advances the selected thread's top index by one, modulo DEPTH. It writes `push_pc_i` there, so that value becomes `top_val_o`.
- R3: A pop on a non-empty stack, with no push and no restore, moves the top index back by one modulo DEPTH. It lowers the entry count by one.
- R4: `ret_tgt_o` equals `top_val_o` + INST_BYTES (4 by default). `ret_valid_o` is the inverse of `empty_o`.
- R5: A restore writes `rest_val_i` at `rest_idx_i` and makes that index the top. The entry count rises by one and saturates at DEPTH.
- R6: A restore takes priority over a push or pop requested in the same cycle. The push value is not written and the pop does not happen.
- R7: A push on a full stack wraps and overwrites the oldest entry, and the count stays at DEPTH. After DEPTH+1 pushes, DEPTH pops empty the stack.
- R8: A pop on an empty stack leaves the top index unchanged. It raises that thread's bit of `underflow_o` for exactly the next cycle.
- R9: Operations on one thread leave the other threads' indices, contents and counts unchanged.
- R10: A push and a pop requested together (without restore) act as a push. The pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| thr_i | input | TID_W | Thread selected for this cycle's operation and read |
| push_i | input | 1 | Push `push_pc_i` |
| pop_i | input | 1 | Pop the top entry |
| restore_i | input | 1 | Write `rest_val_i` at `rest_idx_i` and make it the top |
| push_pc_i | input | AW | Call-site address to push |
| rest_idx_i | input | log2(DEPTH) | Saved top index for restore |
| rest_val_i | input | AW | Saved top value for restore |
| top_val_o | output | AW | Top entry of the selected thread |
| top_idx_o | output | log2(DEPTH) | Top index of the selected thread |
| empty_o | output | 1 | Selected thread holds no entries |
| ret_valid_o | output | 1 | Return target is usable (not empty) |
| ret_tgt_o | output | AW | Predicted return target |
| underflow_o | output | NUM_THREADS | Per-thread one-cycle flag: a pop was attempted while empty |

## Verification
The assertions assume two things about the inputs. First, `thr_i` always names an existing thread. Second, a restore only ever delivers an index that fits the index width. Under those conditions each lane's counter and pointer checks hold for any mix of requests, including push, pop and restore all raised together.

The stimulus draws the thread only from the valid range. It draws restore indices over the full index width, and it sets the three request bits independently. This covers every priority combination. Directed sequences add the full-wrap and empty-pop corners.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_POP     = 2'd1,
    OP_PUSH    = 2'd2,
    OP_RESTORE = 2'd3
  } ras_op_e;

  // restore > push > pop
  function automatic ras_op_e pick_op(input logic push, input logic pop, input logic restore);
    if (restore)   return OP_RESTORE;
    else if (push) return OP_PUSH;
    else if (pop)  return OP_POP;
    else           return OP_NONE;
  endfunction

endpackage

// File: rtl/ras_lane.sv
module ras_lane #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic                     restore_i,
  input  logic [AW-1:0]            push_pc_i,
  input  logic [$clog2(DEPTH)-1:0] rest_idx_i,
  input  logic [AW-1:0]            rest_val_i,
  output logic [AW-1:0]            top_val_o,
  output logic [$clog2(DEPTH)-1:0] top_idx_o,
  output logic                     empty_o,
  output logic                     underflow_o
);
  import ras_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [AW-1:0]    stk_q [DEPTH];
  logic [IDX_W-1:0] tos_q;
  logic [IDX_W-1:0] tos_inc;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_sat_inc;
  logic             uf_q;
  ras_op_e          op;

  assign op          = pick_op(push_i, pop_i, restore_i);
  assign tos_inc     = tos_q + 1'b1;
  assign cnt_sat_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_q <= '0;
      cnt_q <= '0;
      uf_q  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else begin
      uf_q <= 1'b0;
      unique case (op)
        OP_RESTORE: begin
          stk_q[rest_idx_i] <= rest_val_i;
          tos_q             <= rest_idx_i;
          cnt_q             <= cnt_sat_inc;
        end
        OP_PUSH: begin
          stk_q[tos_inc] <= push_pc_i;  // overwrites oldest when full
          tos_q          <= tos_inc;
          cnt_q          <= cnt_sat_inc;
        end
        OP_POP: begin
          if (cnt_q == '0) begin
            uf_q <= 1'b1;
          end else begin
            tos_q <= tos_q - 1'b1;
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign top_val_o   = stk_q[tos_q];
  assign top_idx_o   = tos_q;
  assign empty_o     = (cnt_q == '0);
  assign underflow_o = uf_q;

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  p_restore_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (tos_q == $past(rest_idx_i)) && (top_val_o == $past(rest_val_i)));

  p_push_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !restore_i) |=> (tos_q == IDX_W'($past(tos_q) + 1'b1)) && (top_val_o == $past(push_pc_i)));

  p_pop_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !restore_i && empty_o) |=> underflow_o && $stable(tos_q));

  p_uf_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> $past(pop_i && empty_o));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i && !restore_i) |=> $stable(tos_q) && $stable(empty_o) && !underflow_o);

endmodule

// File: rtl/ras_mt.sv
module ras_mt #(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 8,
  parameter int AW          = 32,
  parameter int INST_BYTES  = 4
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] thr_i,
  input  logic                                          push_i,
  input  logic                                          pop_i,
  input  logic                                          restore_i,
  input  logic [AW-1:0]                                 push_pc_i,
  input  logic [$clog2(DEPTH)-1:0]                      rest_idx_i,
  input  logic [AW-1:0]                                 rest_val_i,
  output logic [AW-1:0]                                 top_val_o,
  output logic [$clog2(DEPTH)-1:0]                      top_idx_o,
  output logic                                          empty_o,
  output logic                                          ret_valid_o,
  output logic [AW-1:0]                                 ret_tgt_o,
  output logic [NUM_THREADS-1:0]                        underflow_o
);
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
  localparam int IDX_W = $clog2(DEPTH);

  logic [AW-1:0]    ln_val [NUM_THREADS];
  logic [IDX_W-1:0] ln_idx [NUM_THREADS];
  logic             ln_empty [NUM_THREADS];

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_lane
    logic sel;
    assign sel = (thr_i == TID_W'(g));

    ras_lane #(.DEPTH(DEPTH), .AW(AW)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push_i & sel),
      .pop_i      (pop_i & sel),
      .restore_i  (restore_i & sel),
      .push_pc_i  (push_pc_i),
      .rest_idx_i (rest_idx_i),
      .rest_val_i (rest_val_i),
      .top_val_o  (ln_val[g]),
      .top_idx_o  (ln_idx[g]),
      .empty_o    (ln_empty[g]),
      .underflow_o(underflow_o[g])
    );
  end

  always_comb begin
    top_val_o = '0;
    top_idx_o = '0;
    empty_o   = 1'b1;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (thr_i == TID_W'(t)) begin
        top_val_o = ln_val[t];
        top_idx_o = ln_idx[t];
        empty_o   = ln_empty[t];
      end
    end
  end

  assign ret_valid_o = !empty_o;
  assign ret_tgt_o   = top_val_o + AW'(INST_BYTES);

  p_ret_tgt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> (ret_tgt_o - top_val_o) == AW'(INST_BYTES));

  p_one_uf_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(underflow_o));

endmodule

// File: tb/ras_mt_tb.sv
module ras_mt_tb;
  localparam int NT = 2;
  localparam int D  = 8;
  localparam int AW = 32;
  localparam int IB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          thr = 1'b0;
  logic          push = 1'b0, pop = 1'b0, rest = 1'b0;
  logic [AW-1:0] push_pc = '0, rest_val = '0;
  logic [2:0]    rest_idx = '0;
  logic [AW-1:0] top_val, ret_tgt;
  logic [2:0]    top_idx;
  logic          empty, ret_valid;
  logic [NT-1:0] uf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [AW-1:0] m_mem [NT][D];
  int            m_tos [NT];
  int            m_cnt [NT];
  logic [NT-1:0] m_uf;

  always #5 clk = ~clk;

  ras_mt #(.NUM_THREADS(NT), .DEPTH(D), .AW(AW), .INST_BYTES(IB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .thr_i(thr), .push_i(push), .pop_i(pop),
    .restore_i(rest), .push_pc_i(push_pc), .rest_idx_i(rest_idx),
    .rest_val_i(rest_val), .top_val_o(top_val), .top_idx_o(top_idx),
    .empty_o(empty), .ret_valid_o(ret_valid), .ret_tgt_o(ret_tgt),
    .underflow_o(uf)
  );

  function automatic logic [AW-1:0] exp_tgt(input logic [AW-1:0] v);
    return v + AW'(IB);
  endfunction

  task automatic cmp(input string tag, input string what, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic m_apply(input int t, input bit ps, input bit pp, input bit rs,
                         input logic [AW-1:0] pc, input int ri, input logic [AW-1:0] rv);
    m_uf = '0;
    if (rs) begin
      m_mem[t][ri] = rv; m_tos[t] = ri;
      if (m_cnt[t] < D) m_cnt[t]++;
    end else if (ps) begin
      m_tos[t] = (m_tos[t] + 1) % D; m_mem[t][m_tos[t]] = pc;
      if (m_cnt[t] < D) m_cnt[t]++;
    end else if (pp) begin
      if (m_cnt[t] == 0) m_uf[t] = 1'b1;
      else begin m_tos[t] = (m_tos[t] + D - 1) % D; m_cnt[t]--; end
    end
  endtask

  task automatic chk(input string tag);
    int t = int'(thr);
    cmp(tag, "top_idx", top_idx, m_tos[t]);
    cmp(tag, "empty", empty, m_cnt[t] == 0);
    cmp(tag, "ret_valid", ret_valid, m_cnt[t] != 0);
    cmp(tag, "underflow", uf, m_uf);
    if (m_cnt[t] != 0) begin
      cmp(tag, "top_val", top_val, m_mem[t][m_tos[t]]);
      cmp(tag, "ret_tgt", ret_tgt, exp_tgt(m_mem[t][m_tos[t]]));
    end
  endtask

  task automatic step(input string tag, input int t, input bit ps, input bit pp, input bit rs,
                      input logic [AW-1:0] pc, input int ri, input logic [AW-1:0] rv);
    @(negedge clk);
    thr = t[0]; push = ps; pop = pp; rest = rs;
    push_pc = pc; rest_idx = ri[2:0]; rest_val = rv;
    @(posedge clk);
    m_apply(t, ps, pp, rs, pc, ri, rv);
    #1;
    chk(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int sv_idx;
    logic [AW-1:0] sv_val;
    for (int t = 0; t < NT; t++) begin
      m_tos[t] = 0; m_cnt[t] = 0;
      for (int i = 0; i < D; i++) m_mem[t][i] = '0;
    end
    m_uf = '0;
    #23;
    // R1 reset state, both threads
    for (int t = 0; t < NT; t++) begin
      thr = t[0]; #1; chk("R1");
    end
    @(negedge clk); rst_n = 1'b1;
    thr = 1'b0; #1; chk("R1");

    // R2 pushes, R4 target
    step("R2", 0, 1, 0, 0, 32'h1000, 0, 0);
    step("R2", 0, 1, 0, 0, 32'h2000, 0, 0);
    step("R4", 0, 1, 0, 0, 32'h3000, 0, 0);
    cmp("R4", "ret_tgt", ret_tgt, 32'h3004);
    // R9 thread 1 untouched
    step("R9", 1, 0, 0, 0, 0, 0, 0);
    cmp("R9", "t1 empty", empty, 1);
    // R3 pop, then R5 restore of saved pair
    thr = 1'b0; #1;
    sv_idx = int'(top_idx); sv_val = top_val;
    step("R3", 0, 0, 1, 0, 0, 0, 0);
    cmp("R3", "top_val", top_val, 32'h2000);
    step("R5", 0, 0, 0, 1, 0, sv_idx, sv_val);
    cmp("R5", "top_val", top_val, 32'h3000);
    // R6 restore beats push and pop
    step("R6", 0, 1, 1, 1, 32'hdead, 1, 32'h5550);
    cmp("R6", "top_idx", top_idx, 1);
    // R10 push+pop acts as push
    step("R10", 0, 1, 1, 0, 32'h7770, 0, 0);
    cmp("R10", "top_val", top_val, 32'h7770);

    // R7 fill thread 1 past full
    for (int i = 0; i <= D; i++) step("R7", 1, 1, 0, 0, 32'h100 * (i + 1), 0, 0);
    for (int i = 0; i < D; i++) step("R7", 1, 0, 1, 0, 0, 0, 0);
    cmp("R7", "empty after D pops", empty, 1);
    // R8 pop on empty, flag for one cycle only
    step("R8", 1, 0, 1, 0, 0, 0, 0);
    cmp("R8", "underflow t1", uf[1], 1);
    step("R8", 1, 0, 0, 0, 0, 0, 0);
    cmp("R8", "underflow cleared", uf[1], 0);

    // random mix: R2 R3 R5 R6 R8 R9 R10
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 3000; n++) begin
      int t = int'($urandom_range(NT - 1));
      bit ps = ($urandom_range(99) < 40);
      bit pp = ($urandom_range(99) < 45);
      bit rs = ($urandom_range(99) < 10);
      step("R2/R3/R5/R9 random", t, ps, pp, rs, $urandom, int'($urandom_range(D - 1)), $urandom);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule